// File: doc/BRIEF.md
# Synchronous Framed Serial Port with Clock Output

This block sends a word to a slave device as a framed serial stream and also drives a bit clock to that slave. Each frame opens with a low start bit and carries 8 or 9 data bits, least significant first. It closes with a high stop bit. The slave returns its own word on the receive line during the same frame. The block samples that word on the clock edges it generates itself.

The bit clock pulses only during data bits. During start and stop bits, and between frames, it rests at the selected idle level. The idle level (polarity) and the active edge (phase) can each be chosen, giving all four combinations. Each bit lasts `DIV` system clock cycles, and each half of a clock pulse lasts `DIV/2` cycles. The host writes a word and the frame settings with a single-cycle load strobe. A busy flag covers the whole frame. When the frame ends, a one-cycle done pulse presents the received word.

Top module: `sync_frame_port`

## Requirements
- R1: After a load accepted on clock edge E0, `serOut` is low for the bit slot E0..E(DIV). Data bit k is driven from edge E(DIV*(k+1)), least significant bit first. The stop bit is high for one slot, and the line stays high while idle.
- R2: With `nineBit`=1 the frame carries 9 data bits, and `loadWord[8]` is sent last, just before the stop bit. With `nineBit`=0 only `loadWord[7:0]` are sent. The frame lasts (data bits + 2) * DIV cycles.
- R3: Outside data bits (start bit, stop bit and idle), `serClk` equals the polarity latched at the last load. This level is 0 after reset.
- R4: With phase 0, `serClk` sits at its idle level for the first DIV/2 cycles of each data bit and at the opposite level for the second half. The leading edge therefore falls mid-bit, and the trailing edge falls at the bit boundary where `serOut` changes.
- R5: With phase 1, `serClk` is at the opposite level for the first half of each data bit and returns to idle for the second half. The leading edge therefore coincides with the `serOut` change, and the trailing edge falls mid-bit.
- R6: Received bit k is the value of `serIn` at edge E(DIV*(k+1)+DIV/2), which is the mid-bit clock edge, assembled LSB first. In 8-bit frames `rxWord[8]` is 0.
- R7: `busy` is high from the edge that accepts a load until the last edge of the stop bit. In the cycle that follows, `done` is high for exactly one cycle with `rxWord` valid.
- R8: A load strobe while `busy` is high is ignored. The word, polarity, phase and length of the running frame are unchanged.
- R9: A load strobe in the `done` cycle is accepted, and the next frame's start bit begins at the following edge.
- R10: After reset, `serOut`=1, `serClk`=0, and `busy`, `done` and `rxWord` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| loadStb | input | 1 | Single-cycle request to start a frame |
| loadWord | input | 9 | Word to send; bit 8 is used only in 9-bit frames |
| nineBit | input | 1 | 1 selects 9 data bits, 0 selects 8 |
| cpol | input | 1 | Idle level of the bit clock |
| cpha | input | 1 | 0: sample on leading edge; 1: sample on trailing edge |
| serIn | input | 1 | Receive data from the slave |
| serOut | output | 1 | Transmit data to the slave |
| serClk | output | 1 | Bit clock to the slave |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle end-of-frame pulse |
| rxWord | output | 9 | Word received in the last frame |

## Verification
Two events can fall in the same cycle: the end-of-frame done pulse and the acceptance of the next load strobe. The bench provokes this by raising the load strobe exactly in the `done` cycle, with a different length, polarity and phase. It then checks that the first frame's received word is still presented, and that the new start bit and clock level appear at the very next edge with no idle slot between frames. A second collision, a load strobe in the middle of a frame, is judged by checking that the running frame's waveform stays bit-exact.

// File: rtl/sync_frame_pkg.sv
package sync_frame_pkg;

  localparam int WORD_W = 9;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_START = 2'd1,
    ST_DATA  = 2'd2,
    ST_STOP  = 2'd3
  } framePhase_e;

  typedef struct packed {
    logic load;       // accept a new frame, drive start bit
    logic shiftOut;   // drive the next data bit
    logic stopBit;    // drive the stop bit
    logic sample;     // capture serIn
    logic finish;     // frame complete, publish word
    logic clkActive;  // bit clock at non-idle level next cycle
  } ctlStrobe_t;

endpackage

// File: rtl/sync_frame_ctrl.sv
module sync_frame_ctrl
  import sync_frame_pkg::*;
#(
  parameter int DIV = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       loadStb,
  input  logic       nineBit,
  input  logic       cpha,
  output ctlStrobe_t strobe,
  output logic       busy,
  output logic       done
);

  localparam int CW   = (DIV > 2) ? $clog2(DIV) : 1;
  localparam int HALF = DIV / 2;
  localparam logic [CW-1:0] CNT_LAST = CW'(DIV - 1);
  localparam logic [CW-1:0] CNT_MID  = CW'(HALF - 1);
  localparam logic [CW-1:0] CNT_HALF = CW'(HALF);

  framePhase_e state, nextState;
  logic [CW-1:0] cnt, nextCnt;
  logic [3:0]    bitIdx, nextIdx;
  logic          nineQ, cphaQ;
  logic [3:0]    lastIdx;

  assign lastIdx = nineQ ? 4'd8 : 4'd7;

  always_comb begin
    nextState = state;
    nextCnt   = cnt;
    nextIdx   = bitIdx;
    strobe    = '0;
    unique case (state)
      ST_IDLE: begin
        if (loadStb) begin
          nextState   = ST_START;
          nextCnt     = '0;
          strobe.load = 1'b1;
        end
      end
      ST_START: begin
        if (cnt == CNT_LAST) begin
          nextState       = ST_DATA;
          nextCnt         = '0;
          nextIdx         = '0;
          strobe.shiftOut = 1'b1;
        end else begin
          nextCnt = cnt + 1'b1;
        end
      end
      ST_DATA: begin
        strobe.sample = (cnt == CNT_MID);
        if (cnt == CNT_LAST) begin
          nextCnt = '0;
          if (bitIdx == lastIdx) begin
            nextState      = ST_STOP;
            strobe.stopBit = 1'b1;
          end else begin
            nextIdx         = bitIdx + 1'b1;
            strobe.shiftOut = 1'b1;
          end
        end else begin
          nextCnt = cnt + 1'b1;
        end
      end
      ST_STOP: begin
        if (cnt == CNT_LAST) begin
          nextState     = ST_IDLE;
          strobe.finish = 1'b1;
        end else begin
          nextCnt = cnt + 1'b1;
        end
      end
      default: nextState = ST_IDLE;
    endcase
    strobe.clkActive = (nextState == ST_DATA) && ((nextCnt < CNT_HALF) == cphaQ);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      bitIdx <= '0;
      nineQ  <= 1'b0;
      cphaQ  <= 1'b0;
      done   <= 1'b0;
    end else begin
      state  <= nextState;
      cnt    <= nextCnt;
      bitIdx <= nextIdx;
      done   <= strobe.finish;
      if (strobe.load) begin
        nineQ <= nineBit;
        cphaQ <= cpha;
      end
    end
  end

  assign busy = (state != ST_IDLE);

  // A strobe during a frame must never restart it
  assert_no_reload_R8: assert property (@(posedge clk) disable iff (!rstN)
    (state != ST_IDLE && loadStb) |=> !(state == ST_START && cnt == '0));

  // End-of-frame indication lasts a single cycle
  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

endmodule

// File: rtl/sync_frame_dpath.sv
module sync_frame_dpath
  import sync_frame_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        strobe,
  input  logic [WORD_W-1:0] loadWord,
  input  logic              nineBit,
  input  logic              cpol,
  input  logic              serIn,
  output logic              serOut,
  output logic              serClk,
  output logic [WORD_W-1:0] rxWord
);

  logic [WORD_W-1:0] txShift;
  logic [WORD_W-1:0] rxShift;
  logic              cpolQ;
  logic              nineQ;
  logic              cpolNow;

  assign cpolNow = strobe.load ? cpol : cpolQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShift <= '0;
      rxShift <= '0;
      cpolQ   <= 1'b0;
      nineQ   <= 1'b0;
      serOut  <= 1'b1;
      serClk  <= 1'b0;
      rxWord  <= '0;
    end else begin
      serClk <= cpolNow ^ strobe.clkActive;
      if (strobe.load) begin
        txShift <= loadWord;
        cpolQ   <= cpol;
        nineQ   <= nineBit;
        serOut  <= 1'b0;
      end else if (strobe.shiftOut) begin
        serOut  <= txShift[0];
        txShift <= {1'b0, txShift[WORD_W-1:1]};
      end else if (strobe.stopBit) begin
        serOut <= 1'b1;
      end
      if (strobe.sample)
        rxShift <= {serIn, rxShift[WORD_W-1:1]};
      if (strobe.finish)
        rxWord <= nineQ ? rxShift : {1'b0, rxShift[WORD_W-1:1]};
    end
  end

  // 8-bit frames never report a ninth received bit
  assert_rx_top_clear_R6: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.finish && !nineQ) |=> (rxWord[WORD_W-1] == 1'b0));

  // Clock never leaves idle level while the stop bit is being started
  assert_stop_clk_idle_R3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.stopBit |=> (serClk == cpolQ));

endmodule

// File: rtl/sync_frame_port.sv
module sync_frame_port
  import sync_frame_pkg::*;
#(
  parameter int DIV = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              loadStb,
  input  logic [WORD_W-1:0] loadWord,
  input  logic              nineBit,
  input  logic              cpol,
  input  logic              cpha,
  input  logic              serIn,
  output logic              serOut,
  output logic              serClk,
  output logic              busy,
  output logic              done,
  output logic [WORD_W-1:0] rxWord
);

  ctlStrobe_t strobe;

  sync_frame_ctrl #(.DIV(DIV)) uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .loadStb (loadStb),
    .nineBit (nineBit),
    .cpha    (cpha),
    .strobe  (strobe),
    .busy    (busy),
    .done    (done)
  );

  sync_frame_dpath uDpath (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .loadWord (loadWord),
    .nineBit  (nineBit),
    .cpol     (cpol),
    .serIn    (serIn),
    .serOut   (serOut),
    .serClk   (serClk),
    .rxWord   (rxWord)
  );

  // Frame opens with a low start bit
  assert_start_low_R1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> !serOut);

  // Frame closes on a high line together with the done pulse
  assert_stop_done_R7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> (serOut && done));

  // Bit clock holds still while no frame runs
  assert_idle_clk_R3: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> $stable(serClk));

endmodule

// File: tb/sim_sync_frame_port.sv
`timescale 1ns/1ps
module sim_sync_frame_port;

  localparam int DIV  = 8;
  localparam int HALF = DIV / 2;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       loadStb = 1'b0;
  logic [8:0] loadWord = '0;
  logic       nineBit = 1'b0;
  logic       cpol = 1'b0;
  logic       cpha = 1'b0;
  logic       serIn = 1'b1;
  logic       serOut, serClk, busy, done;
  logic [8:0] rxWord;

  int compared = 0;
  int mismatched = 0;

  always #4 clk = ~clk;

  sync_frame_port #(.DIV(DIV)) u0 (
    .clk(clk), .rstN(rstN), .loadStb(loadStb), .loadWord(loadWord),
    .nineBit(nineBit), .cpol(cpol), .cpha(cpha), .serIn(serIn),
    .serOut(serOut), .serClk(serClk), .busy(busy), .done(done), .rxWord(rxWord)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [8:0] act, input logic [8:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s %s: actual %h expected %h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic armLoad(input logic [8:0] w, input bit nb, input bit pol, input bit pha);
    loadStb  = 1'b1;
    loadWord = w;
    nineBit  = nb;
    cpol     = pol;
    cpha     = pha;
  endtask

  // Runs one frame whose load was armed at the preceding negedge.
  task automatic runFrame(input logic [8:0] w, input logic [8:0] rxw, input bit nb,
                          input bit pol, input bit pha, input int pokeAt,
                          input bit chain, input logic [8:0] cw, input bit cnb,
                          input bit cpo, input bit cph, input string tag);
    int nBits = nb ? 9 : 8;
    int total = (nBits + 2) * DIV;
    int errOut = 0, errClk = 0, errBusy = 0;
    logic [8:0] expRx = nb ? rxw : {1'b0, rxw[7:0]};
    @(posedge clk);
    @(negedge clk);
    loadStb = 1'b0;
    for (int t = 0; t <= total; t++) begin
      int s = t / DIV;
      int p = t % DIV;
      logic eo, ec;
      if (t == total) begin
        check(serOut == 1'b1, "R1", {tag, " idle line"}, {8'b0, serOut}, 9'h1);
        check(serClk == pol, "R3", {tag, " idle clock"}, {8'b0, serClk}, {8'b0, pol});
        check(!busy && done, "R7", {tag, " busy/done at end"}, {7'b0, busy, done}, 9'h1);
        check(rxWord == expRx, "R6", {tag, " received word"}, rxWord, expRx);
        if (chain) armLoad(cw, cnb, cpo, cph);
      end else begin
        if (s == 0) eo = 1'b0;
        else if (s <= nBits) eo = w[s-1];
        else eo = 1'b1;
        ec = pol;
        if (s >= 1 && s <= nBits) ec = pol ^ ((p < HALF) ? pha : ~pha);
        if (serOut !== eo) begin
          errOut++;
          check(1'b0, nb ? "R2" : "R1", {tag, " serOut"}, {8'b0, serOut}, {8'b0, eo});
        end
        if (serClk !== ec) begin
          errClk++;
          check(1'b0, pha ? "R5" : "R4", {tag, " serClk"}, {8'b0, serClk}, {8'b0, ec});
        end
        if (busy !== 1'b1 || done !== 1'b0) begin
          errBusy++;
          check(1'b0, "R7", {tag, " busy/done in frame"}, {7'b0, busy, done}, 9'h2);
        end
        if (s >= 1 && s <= nBits && p == 0) serIn = rxw[s-1];
        else if (s >= 1 && s <= nBits && p == HALF) serIn = ~rxw[s-1];
        else if (p == 0) serIn = 1'b1;
        if (t == pokeAt) armLoad(9'h0F0, ~nb, ~pol, ~pha);
        if (t == pokeAt + 1) loadStb = 1'b0;
      end
      if (t < total) @(negedge clk);
    end
    check(errOut == 0, nb ? "R2" : "R1", {tag, " data line frame"}, 9'(errOut), 9'h0);
    check(errClk == 0, pha ? "R5" : "R4", {tag, " clock frame"}, 9'(errClk), 9'h0);
    check(errBusy == 0, "R7", {tag, " busy frame"}, 9'(errBusy), 9'h0);
    if (pokeAt >= 0)
      check(errOut == 0 && errClk == 0, "R8", {tag, " mid-frame strobe ignored"},
            9'(errOut + errClk), 9'h0);
    if (!chain) begin
      @(negedge clk);
      check(!done && !busy, "R7", {tag, " done one cycle"}, {7'b0, busy, done}, 9'h0);
      check(serClk == pol, "R3", {tag, " clock rests idle"}, {8'b0, serClk}, {8'b0, pol});
    end
  endtask

  task automatic testReset();
    @(negedge clk);
    check(serOut == 1'b1, "R10", "reset serOut", {8'b0, serOut}, 9'h1);
    check(serClk == 1'b0, "R10", "reset serClk", {8'b0, serClk}, 9'h0);
    check(!busy && !done, "R10", "reset flags", {7'b0, busy, done}, 9'h0);
    check(rxWord == 9'h0, "R10", "reset rxWord", rxWord, 9'h0);
  endtask

  task automatic testMode00();
    @(negedge clk); armLoad(9'h0A5, 1'b0, 1'b0, 1'b0);
    runFrame(9'h0A5, 9'h03C, 1'b0, 1'b0, 1'b0, -1, 1'b0, 9'h0, 1'b0, 1'b0, 1'b0, "R4 mode00");
  endtask

  task automatic testMode01();
    // Bit 8 of loadWord must not be sent in an 8-bit frame (R2)
    @(negedge clk); armLoad(9'h1C3, 1'b0, 1'b0, 1'b1);
    runFrame(9'h0C3, 9'h196, 1'b0, 1'b0, 1'b1, -1, 1'b0, 9'h0, 1'b0, 1'b0, 1'b0, "R5 mode01");
  endtask

  task automatic testNine10();
    @(negedge clk); armLoad(9'h1A5, 1'b1, 1'b1, 1'b0);
    runFrame(9'h1A5, 9'h15A, 1'b1, 1'b1, 1'b0, -1, 1'b0, 9'h0, 1'b0, 1'b0, 1'b0, "R2 nine10");
  endtask

  task automatic testPoke11();
    @(negedge clk); armLoad(9'h133, 1'b1, 1'b1, 1'b1);
    runFrame(9'h133, 9'h0E7, 1'b1, 1'b1, 1'b1, 20, 1'b0, 9'h0, 1'b0, 1'b0, 1'b0, "R8 poke11");
  endtask

  task automatic testChain();
    @(negedge clk); armLoad(9'h05E, 1'b0, 1'b1, 1'b0);
    runFrame(9'h05E, 9'h0B1, 1'b0, 1'b1, 1'b0, -1, 1'b1, 9'h1E1, 1'b1, 1'b0, 1'b1, "R9 chainA");
    runFrame(9'h1E1, 9'h10F, 1'b1, 1'b0, 1'b1, -1, 1'b0, 9'h0, 1'b0, 1'b0, 1'b0, "R9 chainB");
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;
    testReset();
    testMode00();
    testMode01();
    testNine10();
    testPoke11();
    testChain();
    repeat (4) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule